// File: doc/BRIEF.md
# Oversampling Serial Receiver with Three-Sample Vote

This block takes in asynchronous serial characters on a single input line. A clock enable pulses at sixteen times the bit rate, and the block uses it to find the start of each character and to place three samples near the centre of every bit. The value of each bit is the majority of those three samples. The recovered bits go into a shift register, least significant bit first. A character is 8 or 9 data bits long, followed by one stop bit.

When the stop bit has been sampled, the character moves into a holding register together with its ninth bit and a framing-error mark. Software can read that register while the next character is still arriving. The block raises a receive-done flag, which a write-1 strobe clears, and drives an interrupt from that flag when the interrupt enable is set. An overrun flag shows that a character was stored before the previous one had been read.

Top module: `rx_oversample_core`

## Requirements
- R1: After reset, rd_byte is 0x00 and rd_bit8, rdone, frame_err, overrun and rx_irq are all 0.
- R2: In 8-bit mode (wide_en=0), a frame is a low start bit, 8 data bits least significant first, then a stop bit. Its data appears on rd_byte, rd_bit8 reads 0, and rdone goes to 1.
- R3: In 9-bit mode (wide_en=1), the frame carries 9 data bits. The first 8 go to rd_byte and the last one to rd_bit8.
- R4: Each bit is sampled at tick indices 6, 7 and 8 of its 16-tick period, counting from 0 at the start edge. The bit takes the majority value, so one disagreeing sample has no effect and two disagreeing samples flip the bit.
- R5: A falling edge starts a frame. If the start bit votes high, the receiver goes back to idle, stores no character and leaves rdone at 0.
- R6: frame_err is set with a character whose stop bit votes low. It is cleared when a later character with a good stop bit is stored.
- R7: If a character is stored while the previous one is still unread, overrun is set. A pulse on rd_pulse clears overrun.
- R8: A pulse on rdone_clr clears rdone. If a new character is stored in the same cycle, the set takes priority.
- R9: rx_irq is 1 exactly when rdone is 1 and rdone_ie is 1.
- R10: While rx_en is 0, activity on the line stores no character. rd_byte, rdone and frame_err keep their values.
- R11: rd_byte, rd_bit8 and frame_err stay stable while the next character is shifting in. They change only when that character is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Clock enable at 16 times the bit rate |
| rx_en | input | 1 | Receiver enable |
| wide_en | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| line_in | input | 1 | Serial line, idle high |
| rd_pulse | input | 1 | Read strobe for the held character |
| rdone_clr | input | 1 | Write-1 clear of rdone |
| rdone_ie | input | 1 | Interrupt enable for rdone |
| rd_byte | output | 8 | Held character, low 8 bits |
| rd_bit8 | output | 1 | Held ninth data bit |
| rdone | output | 1 | Receive-done flag |
| frame_err | output | 1 | Stop bit of the held character voted low |
| overrun | output | 1 | A character was stored over an unread one |
| rx_irq | output | 1 | Receive-done interrupt |

## Verification
The cases hardest to reach from the ports are the ones that depend on which tick a sample falls on: the single-sample glitch that must be outvoted, the two-sample glitch that must win, and the start pulse that is too short to count. The bench drives the line in steps of one tick, so it chooses exactly which of the three sampling ticks see an inverted level. The other hard-to-reach case is a new character being stored in the same cycle as a clear of rdone. To force it, the bench holds the clear strobe high across the end of a frame and then checks rdone in the store cycle and in the cycle after it.

// File: rtl/rxo_pkg.sv
package rxo_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  function automatic logic maj3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = d_in;
    end else begin : g_many
      assign chain_d = {chain_q[STAGES-2:0], d_in};
    end
  endgenerate

  // line idles high, so the chain resets high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

  assign q_out = chain_q[STAGES-1];

endmodule

// File: rtl/rx_vote.sv
module rx_vote import rxo_pkg::*; #(
  parameter int OSR   = 16,
  parameter int FIRST = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic [$clog2(OSR)-1:0] cnt,
  input  logic                   line,
  output logic                   vote
);

  localparam int CW = $clog2(OSR);

  logic [2:0] samp_q;
  logic [2:0] samp_d;

  // one capture slot per sampling tick
  generate
    for (genvar g = 0; g < 3; g++) begin : g_slot
      assign samp_d[g] = (tick && (cnt == CW'(FIRST + g))) ? line : samp_q[g];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) samp_q <= '1;
    else        samp_q <= samp_d;
  end

  assign vote = maj3(samp_q);

endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm import rxo_pkg::*; #(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic                   tick,
  input  logic                   wide,
  input  logic                   line,
  input  logic                   vote,
  output logic [$clog2(OSR)-1:0] cnt_o,
  output logic                   done_o,
  output logic [DW+1:0]          char_o
);

  localparam int CW   = $clog2(OSR);
  localparam int BW   = $clog2(DW + 2);
  localparam int LAST = OSR - 1;

  rx_state_e      st_q, st_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [BW-1:0]  bit_q, bit_d;
  logic [DW:0]    sh_q, sh_d;
  logic           prev_q, prev_d;
  logic           done_q, done_d;
  logic [DW+1:0]  char_q, char_d;

  logic           cnt_last;
  logic [BW-1:0]  nbits;

  assign cnt_last = (cnt_q == CW'(LAST));
  assign nbits    = wide ? BW'(DW + 1) : BW'(DW);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    char_d = char_q;
    done_d = 1'b0;
    prev_d = tick ? line : prev_q;

    if (!en) begin
      st_d  = RX_IDLE;
      cnt_d = '0;
      bit_d = '0;
    end else if (tick) begin
      if (st_q == RX_IDLE) begin
        // edge tick is index 0 of the start bit
        if (prev_q && !line) begin
          st_d  = RX_START;
          cnt_d = CW'(1);
        end
      end else begin
        cnt_d = cnt_last ? '0 : cnt_q + CW'(1);
        if (cnt_last) begin
          case (st_q)
            RX_START: begin
              bit_d = '0;
              st_d  = vote ? RX_IDLE : RX_DATA;
            end
            RX_DATA: begin
              sh_d  = {vote, sh_q[DW:1]};
              bit_d = bit_q + BW'(1);
              if (bit_q == nbits - BW'(1)) st_d = RX_STOP;
            end
            RX_STOP: begin
              st_d   = RX_IDLE;
              done_d = 1'b1;
              char_d = {~vote,
                        wide ? sh_q[DW] : 1'b0,
                        wide ? sh_q[DW-1:0] : sh_q[DW:1]};
            end
            default: st_d = RX_IDLE;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      prev_q <= 1'b1;
      done_q <= 1'b0;
      char_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      prev_q <= prev_d;
      done_q <= done_d;
      char_q <= char_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign done_o = done_q;
  assign char_o = char_q;

endmodule

// File: rtl/rx_holdbuf.sv
module rx_holdbuf #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] char_in,
  input  logic         rd,
  input  logic         clr,
  output logic [W-1:0] hold_o,
  output logic         rdone_o,
  output logic         ovr_o
);

  logic [W-1:0] hold_q, hold_d;
  logic         unread_q, unread_d;
  logic         ovr_q, ovr_d;
  logic         rdone_q, rdone_d;

  always_comb begin
    hold_d   = hold_q;
    unread_d = unread_q;
    ovr_d    = ovr_q;
    if (load) begin
      hold_d   = char_in;
      unread_d = 1'b1;
      ovr_d    = unread_q & ~rd;
    end else if (rd) begin
      unread_d = 1'b0;
      ovr_d    = 1'b0;
    end
    // a store outranks a clear in the same cycle
    if (load)     rdone_d = 1'b1;
    else if (clr) rdone_d = 1'b0;
    else          rdone_d = rdone_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= '0;
      unread_q <= 1'b0;
      ovr_q    <= 1'b0;
      rdone_q  <= 1'b0;
    end else begin
      hold_q   <= hold_d;
      unread_q <= unread_d;
      ovr_q    <= ovr_d;
      rdone_q  <= rdone_d;
    end
  end

  assign hold_o  = hold_q;
  assign rdone_o = rdone_q;
  assign ovr_o   = ovr_q;

endmodule

// File: rtl/rx_oversample_core.sv
module rx_oversample_core #(
  parameter int OSR         = 16,
  parameter int DW          = 8,
  parameter int VOTE_FIRST  = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick16,
  input  logic          rx_en,
  input  logic          wide_en,
  input  logic          line_in,
  input  logic          rd_pulse,
  input  logic          rdone_clr,
  input  logic          rdone_ie,
  output logic [DW-1:0] rd_byte,
  output logic          rd_bit8,
  output logic          rdone,
  output logic          frame_err,
  output logic          overrun,
  output logic          rx_irq
);

  localparam int CW = $clog2(OSR);
  localparam int HW = DW + 2;

  logic          line_s;
  logic          vote;
  logic [CW-1:0] cnt;
  logic          xfer;
  logic [HW-1:0] char_new;
  logic [HW-1:0] held;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (line_in),
    .q_out (line_s)
  );

  rx_vote #(.OSR(OSR), .FIRST(VOTE_FIRST)) u_vote (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick16),
    .cnt   (cnt),
    .line  (line_s),
    .vote  (vote)
  );

  rx_frame_fsm #(.OSR(OSR), .DW(DW)) u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (rx_en),
    .tick   (tick16),
    .wide   (wide_en),
    .line   (line_s),
    .vote   (vote),
    .cnt_o  (cnt),
    .done_o (xfer),
    .char_o (char_new)
  );

  rx_holdbuf #(.W(HW)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (xfer),
    .char_in (char_new),
    .rd      (rd_pulse),
    .clr     (rdone_clr),
    .hold_o  (held),
    .rdone_o (rdone),
    .ovr_o   (overrun)
  );

  assign rd_byte   = held[DW-1:0];
  assign rd_bit8   = held[DW];
  assign frame_err = held[DW+1];
  assign rx_irq    = rdone & rdone_ie;

endmodule

// File: rtl/rx_oversample_chk.sv
module rx_oversample_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_en,
  input logic          rd_pulse,
  input logic          rdone_clr,
  input logic          xfer,
  input logic [DW-1:0] rd_byte,
  input logic          rd_bit8,
  input logic          rdone,
  input logic          frame_err,
  input logic          overrun
);

  assert_rdone_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> rdone);

  assert_rdone_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rdone && rdone_clr && !xfer) |=> !rdone);

  assert_overrun_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(xfer));

  assert_overrun_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pulse && !xfer) |=> !overrun);

  assert_off_no_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !xfer);

  assert_hold_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> $stable({rd_byte, rd_bit8, frame_err}));

endmodule

bind rx_oversample_core rx_oversample_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_en     (rx_en),
  .rd_pulse  (rd_pulse),
  .rdone_clr (rdone_clr),
  .xfer      (xfer),
  .rd_byte   (rd_byte),
  .rd_bit8   (rd_bit8),
  .rdone     (rdone),
  .frame_err (frame_err),
  .overrun   (overrun)
);

// File: tb/sim_rx_oversample_core.sv
`timescale 1ns/1ps
module sim_rx_oversample_core;

  logic       clk = 1'b0;
  logic       rst_n, tick16, rx_en, wide_en, line_in;
  logic       rd_pulse, rdone_clr, rdone_ie;
  logic [7:0] rd_byte;
  logic       rd_bit8, rdone, frame_err, overrun, rx_irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  rx_oversample_core u0 (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_en(rx_en),
    .wide_en(wide_en), .line_in(line_in), .rd_pulse(rd_pulse),
    .rdone_clr(rdone_clr), .rdone_ie(rdone_ie), .rd_byte(rd_byte),
    .rd_bit8(rd_bit8), .rdone(rdone), .frame_err(frame_err),
    .overrun(overrun), .rx_irq(rx_irq)
  );

  // {glitch mode, wide, stop level, data}; glitch 1 = slot 7 of every
  // data bit inverted, 2 = slots 6 and 7 of data bit 0 inverted
  localparam logic [12:0] VEC [0:7] = '{
    {2'd0, 1'b0, 1'b1, 9'h0A5},
    {2'd0, 1'b1, 1'b1, 9'h13C},
    {2'd1, 1'b0, 1'b1, 9'h05A},
    {2'd2, 1'b0, 1'b1, 9'h0F0},
    {2'd0, 1'b0, 1'b0, 9'h033},
    {2'd0, 1'b0, 1'b1, 9'h1FF},
    {2'd1, 1'b1, 1'b1, 9'h0C3},
    {2'd0, 1'b1, 1'b0, 9'h1FF}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic slot(input logic v);
    line_in = v;
    tick16  = 1'b0;
    repeat (3) @(negedge clk);
    tick16 = 1'b1;
    @(negedge clk);
    tick16 = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) slot(1'b1);
  endtask

  task automatic send_frame(input logic [8:0] d, input logic wide, input logic stopv,
                            input logic [1:0] gm, input int chk_bit,
                            input logic [7:0] hold_exp);
    int nb;
    nb = wide ? 9 : 8;
    wide_en = wide;
    for (int idx = 0; idx <= nb + 1; idx++) begin
      logic val;
      if (idx == 0)           val = 1'b0;
      else if (idx == nb + 1) val = stopv;
      else                    val = d[idx-1];
      for (int s = 0; s < 16; s++) begin
        logic v;
        v = val;
        if (idx >= 1 && idx <= nb && gm == 2'd1 && s == 7) v = ~v;
        if (idx == 1 && gm == 2'd2 && (s == 6 || s == 7)) v = ~v;
        slot(v);
      end
      if (chk_bit > 0 && idx == chk_bit)
        check("R11 held byte mid-frame", {8'h0, rd_byte}, {8'h0, hold_exp});
    end
  endtask

  task automatic do_read();
    rd_pulse = 1'b1;
    @(negedge clk);
    rd_pulse = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_clear();
    rdone_clr = 1'b1;
    @(negedge clk);
    rdone_clr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick16 = 1'b0; rx_en = 1'b1; wide_en = 1'b0; line_in = 1'b1;
    rd_pulse = 1'b0; rdone_clr = 1'b0; rdone_ie = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 rd_byte", {8'h0, rd_byte}, 16'h0);
    check("R1 flags", {11'h0, rd_bit8, rdone, frame_err, overrun, rx_irq}, 16'h0);
    rst_n = 1'b1;
    idle(4);

    // table walk: R2 R3 R4 R6 R8
    for (int k = 0; k < 8; k++) begin
      logic [1:0] gm;
      logic       wd, sv;
      logic [8:0] dd;
      logic [7:0] eb;
      logic       e8;
      {gm, wd, sv, dd} = VEC[k];
      eb = dd[7:0];
      if (gm == 2'd2) eb[0] = ~eb[0];
      e8 = wd ? dd[8] : 1'b0;
      send_frame(dd, wd, sv, gm, -1, 8'h0);
      idle(2);
      check($sformatf("R2 R3 R4 byte vec%0d", k), {8'h0, rd_byte}, {8'h0, eb});
      check($sformatf("R3 bit8 vec%0d", k), {15'h0, rd_bit8}, {15'h0, e8});
      check($sformatf("R6 frame_err vec%0d", k), {15'h0, frame_err}, {15'h0, ~sv});
      check($sformatf("R2 rdone vec%0d", k), {15'h0, rdone}, 16'h1);
      check($sformatf("R7 no overrun vec%0d", k), {15'h0, overrun}, 16'h0);
      do_read();
      do_clear();
      check($sformatf("R8 cleared vec%0d", k), {15'h0, rdone}, 16'h0);
    end

    // R5: start pulse too short to survive the vote
    wide_en = 1'b0;
    for (int s = 0; s < 5; s++) slot(1'b0);
    idle(40);
    check("R5 no store after short start", {15'h0, rdone}, 16'h0);
    check("R5 byte kept", {8'h0, rd_byte}, 16'h00FF);
    send_frame(9'h06E, 1'b0, 1'b1, 2'd0, -1, 8'h0);
    idle(2);
    check("R5 next frame ok", {8'h0, rd_byte}, 16'h006E);
    check("R6 frame_err cleared by good frame", {15'h0, frame_err}, 16'h0);

    // R9 interrupt gating
    rdone_ie = 1'b1;
    @(negedge clk);
    check("R9 irq on", {15'h0, rx_irq}, 16'h1);
    rdone_ie = 1'b0;
    @(negedge clk);
    check("R9 irq masked", {15'h0, rx_irq}, 16'h0);
    rdone_ie = 1'b1;
    do_clear();
    check("R9 irq after clear", {15'h0, rx_irq}, 16'h0);
    rdone_ie = 1'b0;
    do_read();

    // R7 and R11: second char arrives unread over the first
    send_frame(9'h011, 1'b0, 1'b1, 2'd0, -1, 8'h0);
    idle(2);
    check("R7 no overrun after first", {15'h0, overrun}, 16'h0);
    send_frame(9'h022, 1'b0, 1'b1, 2'd0, 4, 8'h11);
    idle(2);
    check("R7 overrun set", {15'h0, overrun}, 16'h1);
    check("R7 newest byte held", {8'h0, rd_byte}, 16'h0022);
    do_read();
    check("R7 overrun cleared by read", {15'h0, overrun}, 16'h0);
    do_clear();

    // R8: clear held high through the store cycle
    rdone_clr = 1'b1;
    send_frame(9'h05C, 1'b0, 1'b1, 2'd0, -1, 8'h0);
    @(negedge clk);
    check("R8 set wins over clear", {15'h0, rdone}, 16'h1);
    @(negedge clk);
    check("R8 clear next cycle", {15'h0, rdone}, 16'h0);
    rdone_clr = 1'b0;
    do_read();

    // R10: disabled receiver ignores the line
    rx_en = 1'b0;
    send_frame(9'h099, 1'b0, 1'b0, 2'd0, -1, 8'h0);
    idle(2);
    check("R10 rdone unchanged", {15'h0, rdone}, 16'h0);
    check("R10 byte unchanged", {8'h0, rd_byte}, 16'h005C);
    check("R10 frame_err unchanged", {15'h0, frame_err}, 16'h0);
    rx_en = 1'b1;
    idle(2);
    send_frame(9'h077, 1'b0, 1'b1, 2'd0, -1, 8'h0);
    idle(2);
    check("R10 reenabled byte", {8'h0, rd_byte}, 16'h0077);
    check("R10 reenabled rdone", {15'h0, rdone}, 16'h1);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule